// File: doc/BRIEF.md
# Circular Command Queue Fetch Engine

The engine drains a ring of 32-byte commands that software places in memory. The register bus lives outside this block. The queue base address, its size in 4 KiB pages, the write offset, the enable bit and the base-valid bit all arrive as plain inputs. The engine owns the read offset and the stalled flag and drives them out. It reads memory through a simple request/response port that returns one 64-bit word per request.

When the queue is runnable, the engine fetches the pending window into a small local buffer. If the window crosses the end of the ring, it splits into a tail part and a head part. The engine then publishes the new read offset together with a one-cycle pulse that clears the producer's retry flag. Only after that does it execute the buffered commands, one per clock cycle.

Three opcodes are recognised:
- A collection-map command writes a 256-entry table of (valid, target processor) pairs.
- An invalidate-all command requests a configuration-table reload.
- A sync command does nothing.

Any other opcode, or an out-of-range collection number, records a diagnostic code and bumps an error counter, but the queue keeps running. A failed memory read stalls the queue and leaves the read offset where it was.

Top module: `cmdq_fetch_engine`

## Requirements
- R1: The engine issues memory reads only while the enable input is 1, the base-valid input is 1, the stalled flag is 0 and the read offset differs from the write offset; otherwise the read offset does not move.
- R2: The ring length is (size field + 1) × 4096 bytes. Every memory read targets base + offset with the offset inside the ring. A window whose write offset is not above the read offset is fetched from the read offset to the ring end, then from offset 0 up to the write offset.
- R3: After the last word of a pass arrives, the read offset takes the pass end offset and `retry_clr` pulses for one cycle, before any command of that pass takes effect.
- R4: One pass fetches at most BUF_CMDS commands. A longer window is drained in successive passes, each committing its own end offset, including an end offset of 0 at the ring end.
- R5: Byte 0 of word 0 is the opcode. Opcode 0x09 (collection map) takes its fields from word 2: collection number in bits [15:0], target in bits [31:16], valid in bit 63. An in-range number writes the table entry, which the lookup port shows as `coll_valid` and `coll_target`.
- R6: A collection map with a number of NUM_COLL (256) or more leaves the table unchanged, sets `diag` to 4, adds 1 to `err_count` and does not stall.
- R7: Opcode 0x0D (invalidate all) with a collection number below NUM_COLL pulses `inval_req` for one cycle. With a larger number it sets `diag` to 3 and adds 1 to `err_count`.
- R8: Opcode 0x05 (sync) has no visible effect. Any unlisted opcode sets `diag` to 1 and adds 1 to `err_count`, without stalling.
- R9: A read returned with `mem_rerr` sets `diag` to 2, adds 1 to `err_count` and sets `stalled`, which then stays set until reset. The read offset is unchanged and no command of that pass executes.
- R10: After reset the read offset, `err_count`, `diag`, `stalled`, `busy`, `inval_req` and all table entries are 0.
- R11: Commands execute one per cycle in ring order, so a later collection map to the same number overrides an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_enable | input | 1 | Global enable bit from the register bus |
| cbase_valid | input | 1 | Queue base register valid bit |
| cbase_addr | input | ADDR_W | Queue base address, 4 KiB aligned |
| cbase_size | input | SIZE_W | Queue size in pages minus one |
| wr_off | input | SIZE_W+12 | Producer write byte offset, 32-byte aligned |
| rd_off | output | SIZE_W+12 | Consumer read byte offset |
| stalled | output | 1 | Queue stalled by a fetch failure |
| retry_clr | output | 1 | One-cycle pulse: clear the write register's retry bit |
| busy | output | 1 | Engine is fetching or executing |
| mem_req | output | 1 | Memory read request (one 64-bit word) |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_rvalid | input | 1 | Read response valid |
| mem_rerr | input | 1 | Read response carries an error |
| mem_rdata | input | 64 | Read response data |
| inval_req | output | 1 | One-cycle configuration-table reload request |
| diag | output | 3 | Last diagnostic code |
| err_count | output | CNT_W | Count of recorded errors |
| coll_idx | input | log2(NUM_COLL) | Collection table lookup index |
| coll_valid | output | 1 | Valid bit of the looked-up entry |
| coll_target | output | TGT_W | Target of the looked-up entry |

## Verification
The bench builds the engine with SIZE_W=2, ADDR_W=32 and BUF_CMDS=4, and uses a one-page ring of 128 slots. The four-entry buffer makes multi-pass draining occur on short windows. It also makes a pass that ends exactly at the ring end, committing offset 0, reachable. The small ring lets wrap-around fetches happen after about a hundred filler commands. An injected read error on a chosen word exercises the stall path.

// File: rtl/cmdq_fetch_engine.sv
module cmdq_fetch_engine #(
  parameter int SIZE_W = 8,
  parameter int ADDR_W = 48,
  parameter int BUF_CMDS = 16,
  parameter int NUM_COLL = 256,
  parameter int CID_W = 16,
  parameter int TGT_W = 16,
  parameter int CNT_W = 32,
  parameter logic [7:0] OP_SYNC = 8'h05,
  parameter logic [7:0] OP_MAPC = 8'h09,
  parameter logic [7:0] OP_INVALL = 8'h0D
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        q_enable,
  input  logic                        cbase_valid,
  input  logic [ADDR_W-1:0]           cbase_addr,
  input  logic [SIZE_W-1:0]           cbase_size,
  input  logic [SIZE_W+11:0]          wr_off,
  output logic [SIZE_W+11:0]          rd_off,
  output logic                        stalled,
  output logic                        retry_clr,
  output logic                        busy,
  output logic                        mem_req,
  output logic [ADDR_W-1:0]           mem_addr,
  input  logic                        mem_rvalid,
  input  logic                        mem_rerr,
  input  logic [63:0]                 mem_rdata,
  output logic                        inval_req,
  output logic [2:0]                  diag,
  output logic [CNT_W-1:0]            err_count,
  input  logic [$clog2(NUM_COLL)-1:0] coll_idx,
  output logic                        coll_valid,
  output logic [TGT_W-1:0]            coll_target
);
  localparam int CI_W = SIZE_W + 7;
  localparam int BC_W = $clog2(BUF_CMDS + 1);
  localparam int BI_W = $clog2(BUF_CMDS);
  localparam int CT_W = $clog2(NUM_COLL);
  localparam logic [2:0] DG_UNKNOWN = 3'd1;
  localparam logic [2:0] DG_ADDR = 3'd2;
  localparam logic [2:0] DG_INVALL = 3'd3;
  localparam logic [2:0] DG_MAPC = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EXEC} state_t;
  state_t state;

  logic [CI_W-1:0] rd_ci, wr_ci, cur_ci, nxt_ci;
  logic [CI_W:0]   qlen_ci, pend_ci;
  logic [BC_W-1:0] chunk, fill, ncmd;
  logic [BI_W-1:0] xi;
  logic [1:0]      wi;
  logic            waiting, runnable, last_word, last_cmd, rsp_ok;

  logic [7:0]       op_buf [BUF_CMDS];
  logic             v_buf  [BUF_CMDS];
  logic [TGT_W-1:0] t_buf  [BUF_CMDS];
  logic [CID_W-1:0] id_buf [BUF_CMDS];

  logic             coll_v [NUM_COLL];
  logic [TGT_W-1:0] coll_t [NUM_COLL];

  logic [7:0]       x_op;
  logic             x_v, x_inrange;
  logic [TGT_W-1:0] x_t;
  logic [CID_W-1:0] x_id;

  assign wr_ci   = wr_off[SIZE_W+11:5];
  assign rd_off  = {rd_ci, 5'd0};
  assign qlen_ci = ((CI_W+1)'(cbase_size) + (CI_W+1)'(1)) << 7;
  assign pend_ci = (wr_ci > rd_ci) ? (CI_W+1)'(wr_ci - rd_ci)
                                   : qlen_ci - (CI_W+1)'(rd_ci) + (CI_W+1)'(wr_ci);
  assign chunk   = (pend_ci > (CI_W+1)'(BUF_CMDS)) ? BC_W'(BUF_CMDS) : BC_W'(pend_ci);
  assign runnable = q_enable && cbase_valid && !stalled && (wr_ci != rd_ci);
  assign nxt_ci  = ((CI_W+1)'(cur_ci) + (CI_W+1)'(1) == qlen_ci) ? '0 : cur_ci + CI_W'(1);

  assign busy      = (state != S_IDLE);
  assign mem_req   = (state == S_FETCH) && !waiting;
  assign mem_addr  = cbase_addr + ADDR_W'({cur_ci, wi, 3'b000});
  assign last_word = (wi == 2'd3);
  assign last_cmd  = (fill + BC_W'(1) == ncmd);
  assign rsp_ok    = (state == S_FETCH) && waiting && mem_rvalid && !mem_rerr;

  assign x_op      = op_buf[xi];
  assign x_v       = v_buf[xi];
  assign x_t       = t_buf[xi];
  assign x_id      = id_buf[xi];
  assign x_inrange = ({1'b0, x_id} < (CID_W+1)'(NUM_COLL));

  assign coll_valid  = coll_v[coll_idx];
  assign coll_target = coll_t[coll_idx];

  always_ff @(posedge clk) begin
    if (rsp_ok) begin
      if (wi == 2'd0) op_buf[fill[BI_W-1:0]] <= mem_rdata[7:0];
      if (wi == 2'd2) begin
        v_buf[fill[BI_W-1:0]]  <= mem_rdata[63];
        t_buf[fill[BI_W-1:0]]  <= mem_rdata[16 +: TGT_W];
        id_buf[fill[BI_W-1:0]] <= mem_rdata[CID_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_COLL; i++) begin
        coll_v[i] <= 1'b0;
        coll_t[i] <= '0;
      end
    end else if (state == S_EXEC && x_op == OP_MAPC && x_inrange) begin
      coll_v[x_id[CT_W-1:0]] <= x_v;
      coll_t[x_id[CT_W-1:0]] <= x_t;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      rd_ci     <= '0;
      cur_ci    <= '0;
      wi        <= '0;
      fill      <= '0;
      ncmd      <= '0;
      xi        <= '0;
      waiting   <= 1'b0;
      stalled   <= 1'b0;
      retry_clr <= 1'b0;
      inval_req <= 1'b0;
      diag      <= '0;
      err_count <= '0;
    end else begin
      retry_clr <= 1'b0;
      inval_req <= 1'b0;
      case (state)
        S_IDLE: if (runnable) begin
          state   <= S_FETCH;
          cur_ci  <= rd_ci;
          wi      <= '0;
          fill    <= '0;
          ncmd    <= chunk;
          waiting <= 1'b0;
        end
        S_FETCH: begin
          if (mem_req) waiting <= 1'b1;
          if (waiting && mem_rvalid) begin
            waiting <= 1'b0;
            if (mem_rerr) begin
              stalled   <= 1'b1;
              diag      <= DG_ADDR;
              err_count <= err_count + CNT_W'(1);
              state     <= S_IDLE;
            end else begin
              wi <= wi + 2'd1;
              if (last_word) begin
                cur_ci <= nxt_ci;
                fill   <= fill + BC_W'(1);
                if (last_cmd) begin
                  rd_ci     <= nxt_ci;
                  retry_clr <= 1'b1;
                  xi        <= '0;
                  state     <= S_EXEC;
                end
              end
            end
          end
        end
        S_EXEC: begin
          xi <= xi + BI_W'(1);
          if (BC_W'(xi) + BC_W'(1) == ncmd) state <= S_IDLE;
          if (x_op == OP_MAPC) begin
            if (!x_inrange) begin
              diag      <= DG_MAPC;
              err_count <= err_count + CNT_W'(1);
            end
          end else if (x_op == OP_INVALL) begin
            if (x_inrange) inval_req <= 1'b1;
            else begin
              diag      <= DG_INVALL;
              err_count <= err_count + CNT_W'(1);
            end
          end else if (x_op != OP_SYNC) begin
            diag      <= DG_UNKNOWN;
            err_count <= err_count + CNT_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmdq_fetch_engine_chk.sv
module cmdq_fetch_engine_chk #(
  parameter int SIZE_W = 8,
  parameter int ADDR_W = 48,
  parameter int CNT_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  cbase_addr,
  input logic [SIZE_W-1:0]  cbase_size,
  input logic [SIZE_W+11:0] rd_off,
  input logic               stalled,
  input logic               retry_clr,
  input logic               mem_req,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic               inval_req,
  input logic [2:0]         diag,
  input logic [CNT_W-1:0]   err_count
);
  // R9
  stall_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> stalled);

  // R9
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stalled) |-> diag == 3'd2);

  // R3
  rd_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_off) |-> retry_clr);

  // R3
  commit_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_clr |-> !inval_req && $stable(err_count));

  // R1
  no_fetch_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !stalled);

  // R2
  addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr - cbase_addr) < ((ADDR_W'(cbase_size) + ADDR_W'(1)) << 12));

  // R6
  err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_count) |-> err_count == $past(err_count) + CNT_W'(1));
endmodule

bind cmdq_fetch_engine cmdq_fetch_engine_chk #(
  .SIZE_W(SIZE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cbase_addr(cbase_addr), .cbase_size(cbase_size),
  .rd_off(rd_off), .stalled(stalled), .retry_clr(retry_clr), .mem_req(mem_req),
  .mem_addr(mem_addr), .inval_req(inval_req), .diag(diag), .err_count(err_count)
);

// File: tb/tb_cmdq_fetch_engine.sv
module tb_cmdq_fetch_engine;
  localparam int SW = 2;
  localparam int AW = 32;
  localparam int BUF = 4;
  localparam int QW = 512;
  localparam int QC = 128;
  localparam logic [AW-1:0] BASE = 32'h0001_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic q_enable = 1'b0, cbase_valid = 1'b0;
  logic [AW-1:0] cbase_addr = BASE;
  logic [SW-1:0] cbase_size = '0;
  logic [SW+11:0] wr_off = '0;
  logic [SW+11:0] rd_off;
  logic stalled, retry_clr, busy, mem_req, inval_req;
  logic [AW-1:0] mem_addr;
  logic mem_rvalid = 1'b0, mem_rerr = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic [2:0] diag;
  logic [31:0] err_count;
  logic [7:0] coll_idx = '0;
  logic coll_valid;
  logic [15:0] coll_target;

  cmdq_fetch_engine #(.SIZE_W(SW), .ADDR_W(AW), .BUF_CMDS(BUF)) dut (
    .clk(clk), .rst_n(rst_n), .q_enable(q_enable), .cbase_valid(cbase_valid),
    .cbase_addr(cbase_addr), .cbase_size(cbase_size), .wr_off(wr_off),
    .rd_off(rd_off), .stalled(stalled), .retry_clr(retry_clr), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rerr(mem_rerr), .mem_rdata(mem_rdata), .inval_req(inval_req),
    .diag(diag), .err_count(err_count), .coll_idx(coll_idx),
    .coll_valid(coll_valid), .coll_target(coll_target));

  int checks = 0, fails = 0;
  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: one word per request, two-cycle latency
  logic [63:0] mem [QW];
  int bad_idx = -1;
  int dly = 0;
  int widx;
  logic [AW-1:0] lat_addr = '0;
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    mem_rerr <= 1'b0;
    if (dly == 1) begin
      widx = int'((lat_addr - BASE) >> 3);
      mem_rvalid <= 1'b1;
      mem_rdata <= (widx >= 0 && widx < QW) ? mem[widx] : 64'd0;
      mem_rerr <= (widx == bad_idx);
    end
    if (dly > 0) dly <= dly - 1;
    if (mem_req) begin
      lat_addr <= mem_addr;
      dly <= 2;
    end
  end

  // scoreboard: kind 0 commit, 1 invalidate pulse, 2 error with diag code
  typedef struct {int kind; int val; string req;} ev_t;
  ev_t expq[$];
  task automatic push(int kind, int val, string req);
    ev_t e;
    e.kind = kind; e.val = val; e.req = req;
    expq.push_back(e);
  endtask

  task automatic pop_cmp(int kind, int val);
    ev_t e;
    if (expq.size() == 0) chk("R3 unexpected event", kind * 65536 + val, -1);
    else begin
      e = expq.pop_front();
      chk(e.req, kind * 65536 + val, e.kind * 65536 + e.val);
    end
  endtask

  logic [31:0] prev_err = '0;
  always @(negedge clk) begin
    if (!rst_n) prev_err = '0;
    else begin
      if (mem_req) chk("R2 address inside ring",
                       (mem_addr >= BASE && mem_addr < BASE + (int'(cbase_size) + 1) * 4096), 1);
      if (retry_clr) pop_cmp(0, int'(rd_off));
      if (inval_req) pop_cmp(1, 0);
      if (err_count != prev_err) begin
        pop_cmp(2, int'(diag));
        prev_err = err_count;
      end
    end
  end

  // command model
  int sh_op [QC];
  int sh_id [QC];
  int sh_t  [QC];
  int sh_v  [QC];
  int cm_v [256];
  int cm_t [256];
  int rd_m = 0;

  task automatic put_cmd(int ci, int op, int id, int tgt, int v);
    mem[ci*4]   = 64'(op);
    mem[ci*4+1] = '0;
    mem[ci*4+2] = {v[0], 31'd0, tgt[15:0], id[15:0]};
    mem[ci*4+3] = '0;
    sh_op[ci] = op; sh_id[ci] = id; sh_t[ci] = tgt; sh_v[ci] = v;
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin cm_v[i] = 0; cm_t[i] = 0; end
    rd_m = 0;
  endtask

  task automatic run_queue(int new_wr);
    int r = rd_m;
    while (r != new_wr) begin
      int pend = (new_wr > r) ? new_wr - r : QC - r + new_wr;
      int n = (pend > BUF) ? BUF : pend;
      int e = (r + n) % QC;
      push(0, e * 32, "R3 R4 commit offset");
      for (int k = 0; k < n; k++) begin
        int ci = (r + k) % QC;
        case (sh_op[ci])
          9: if (sh_id[ci] < 256) begin
               cm_v[sh_id[ci]] = sh_v[ci];
               cm_t[sh_id[ci]] = sh_t[ci];
             end else push(2, 4, "R6 map range error");
          13: if (sh_id[ci] < 256) push(1, 0, "R7 invalidate pulse");
              else push(2, 3, "R7 invalidate range error");
          5: ;
          default: push(2, 1, "R8 unknown opcode");
        endcase
      end
      r = e;
    end
    wr_off = (SW+12)'(new_wr * 32);
    q_enable = 1'b1;
    cbase_valid = 1'b1;
    repeat (2) @(negedge clk);
    while (busy || int'(rd_off) != new_wr * 32) @(negedge clk);
    repeat (2) @(negedge clk);
    rd_m = new_wr;
    chk("R3 read offset after drain", rd_off, new_wr * 32);
    chk("R3 scoreboard drained", expq.size(), 0);
  endtask

  task automatic look(int id, string req);
    coll_idx = 8'(id);
    @(negedge clk);
    chk(req, coll_valid, cm_v[id]);
    chk(req, coll_target, cm_t[id]);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int e0;
    for (int i = 0; i < QW; i++) mem[i] = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 rd_off", rd_off, 0);
    chk("R10 stalled", stalled, 0);
    chk("R10 err_count", err_count, 0);
    chk("R10 diag", diag, 0);
    chk("R10 busy", busy, 0);
    look(5, "R10 table empty");

    // R1: not runnable while disabled or base invalid
    put_cmd(0, 9, 5, 16'h1234, 1);
    put_cmd(1, 5, 0, 0, 0);
    wr_off = 14'd64;
    repeat (30) @(negedge clk);
    chk("R1 disabled keeps rd_off", rd_off, 0);
    q_enable = 1'b1;
    repeat (30) @(negedge clk);
    chk("R1 base invalid keeps rd_off", rd_off, 0);
    chk("R1 no events", expq.size(), 0);

    // R5 basic map + sync
    run_queue(2);
    look(5, "R5 map entry");

    // R4 multi-pass, R11 ordering, R7 boundary
    put_cmd(2, 9, 9, 16'h00AA, 1);
    put_cmd(3, 9, 9, 16'h00BB, 1);
    put_cmd(4, 13, 7, 0, 0);
    put_cmd(5, 5, 0, 0, 0);
    put_cmd(6, 13, 255, 0, 0);
    put_cmd(7, 9, 255, 16'h0077, 1);
    run_queue(8);
    look(9, "R11 later map wins");
    chk("R11 target value", coll_target, 16'h00BB);
    look(255, "R5 map top entry");

    // R6 R7 R8 errors do not stall
    put_cmd(8, 9, 300, 16'h0055, 1);
    put_cmd(9, 13, 256, 0, 0);
    put_cmd(10, 8'h42, 0, 0, 0);
    put_cmd(11, 5, 0, 0, 0);
    run_queue(12);
    chk("R6 no stall after command errors", stalled, 0);
    chk("R8 last diag code", diag, 1);
    chk("R6 error count", err_count, 3);

    // R5 valid=0 clears
    put_cmd(12, 9, 5, 16'h0000, 0);
    run_queue(13);
    look(5, "R5 map clear entry");

    // R2 wrap: fill to slot 124, then window 124..2
    for (int i = 13; i < 124; i++) put_cmd(i, 5, 0, 0, 0);
    run_queue(124);
    put_cmd(124, 9, 20, 16'h00A1, 1);
    put_cmd(125, 5, 0, 0, 0);
    put_cmd(126, 13, 3, 0, 0);
    put_cmd(127, 9, 21, 16'h00B2, 1);
    put_cmd(0, 9, 22, 16'h00C3, 1);
    put_cmd(1, 5, 0, 0, 0);
    put_cmd(2, 13, 256, 0, 0);
    run_queue(3);
    look(20, "R2 tail burst entry");
    look(21, "R2 last slot entry");
    look(22, "R2 head burst entry");
    // R8 sync-only run ending at offset 0 (no head burst)
    e0 = int'(err_count);
    for (int i = 3; i < QC; i++) put_cmd(i, 5, 0, 0, 0);
    run_queue(0);
    chk("R8 sync leaves error count", err_count, e0);
    chk("R4 end offset zero", rd_off, 0);

    // R9 fetch error
    put_cmd(0, 9, 30, 16'h0005, 1);
    put_cmd(1, 5, 0, 0, 0);
    put_cmd(2, 13, 0, 0, 0);
    bad_idx = 6;
    push(2, 2, "R9 fetch error diag");
    wr_off = 14'd64;
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R9 stalled set", stalled, 1);
    chk("R9 rd_off unchanged", rd_off, 0);
    chk("R9 diag", diag, 2);
    look(30, "R9 no command executed");
    wr_off = 14'd96;
    repeat (40) @(negedge clk);
    chk("R1 stalled keeps rd_off", rd_off, 0);
    chk("R9 stall persists", stalled, 1);
    chk("R9 scoreboard drained", expq.size(), 0);

    // reset clears stall, queue then runs
    q_enable = 1'b0;
    rst_n = 1'b0;
    bad_idx = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    chk("R10 stall cleared", stalled, 0);
    chk("R10 err_count cleared", err_count, 0);
    run_queue(3);
    look(30, "R5 map after recovery");

    finish_run();
  end
endmodule